// File: doc/BRIEF.md
# Serial Channel Flow-Control Status Register

This block keeps the flow-control status word for one serial channel. It collects single-cycle event strobes from the receiver and the transmitter. The receiver reports a stop character seen and a special character stored. The transmitter reports a stop character sent and a resume character sent. The block combines these events with live pin and strap levels into an 8-bit word that the host reads through a simple register port. Two bits, the local halt flag and the remote halt flag, can be cleared by the host. Clearing the remote halt flag also sends the transmitter a one-cycle request to emit a resume character.

The read word is combinational from the stored flags and the live inputs. Flag updates from events, writes and reads take effect at the next rising clock edge. The host may drop the local halt flag to restart the local transmitter after a stop character, and may drop the remote halt flag to let the far end resume. Every other bit is read-only.

Top module: `flow_status_reg`

## Requirements
- R1: Bit 0 (local halt) becomes 1 one clock after `rxXoffDet` is high, and the `txHalted` output always equals bit 0.
- R2: A register write whose data bit 0 is 0 clears bit 0 one clock later. A write with data bit 0 equal to 1 leaves bit 0 unchanged. If `rxXoffDet` is high in the same cycle as a clearing write, bit 0 becomes 1.
- R3: Bit 1 (remote halt) becomes 1 one clock after `txXoffSent`, and becomes 0 one clock after `txXonSent`. When both strobes are high in the same cycle, bit 1 becomes 1.
- R4: A write with data bit 1 equal to 0 while bit 1 is 1 clears bit 1 and raises `xonRequest` for exactly the following cycle. If `txXoffSent` is high in that same cycle, bit 1 stays 1 and no pulse is produced. A write with data bit 1 equal to 1 changes nothing.
- R5: An active-low `rstN` clears bits 0, 1 and 4 and `xonRequest`. A high `chanSwReset` clears bits 0 and 1 and `xonRequest` at the next edge and overrides any event in the same cycle.
- R6: With `loopbackEn` low, bit 2 reads the inverse of `rtsPin` and bit 3 reads the inverse of `dtrPin`. With `loopbackEn` high, these bits read `rtsFlowHalt` and `dtrFlowHalt`.
- R7: Bit 4 (special character stored) becomes 1 one clock after `rxSpecialStored` and becomes 0 one clock after a cycle with `regRdEn` high. If both are high in the same cycle, bit 4 is 1.
- R8: Bit 5 reads `fifoSelPin` unlatched, and bit 6 reads `fifoDeep` (0 selects 16 entries, 1 selects 128 entries).
- R9: Bit 7 reads 1 exactly when both `txFifoEmpty` and `txShiftEmpty` are 1.
- R10: Data bits 7 to 2 of a write have no effect on the read word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| chanSwReset | input | 1 | Synchronous channel software reset |
| rxXoffDet | input | 1 | Receiver saw a stop character |
| rxSpecialStored | input | 1 | Receiver stored a special character |
| txXoffSent | input | 1 | Transmitter sent a stop character |
| txXonSent | input | 1 | Transmitter sent a resume character |
| txFifoEmpty | input | 1 | Transmit FIFO is empty |
| txShiftEmpty | input | 1 | Transmit shift register is empty |
| rtsPin | input | 1 | Level of the RTS output pin |
| dtrPin | input | 1 | Level of the DTR output pin |
| loopbackEn | input | 1 | Channel is in loopback mode |
| rtsFlowHalt | input | 1 | Internal RTS flow-control halt state |
| dtrFlowHalt | input | 1 | Internal DTR flow-control halt state |
| fifoSelPin | input | 1 | FIFO-select pin level |
| fifoDeep | input | 1 | FIFO depth strap |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Status word |
| txHalted | output | 1 | Local transmitter halt |
| xonRequest | output | 1 | One-cycle request to send a resume character |

## Verification
Bits 2, 3, 5, 6 and 7 are due in the same cycle as the input that drives them. Bits 0, 1 and 4, `txHalted` and `xonRequest` are due one clock after the cycle that holds the causing strobe or write. The bench drives every input just after a falling edge. It compares all outputs one nanosecond later against a model that steps once per rising edge. Combinational bits are therefore checked against the inputs of the current cycle, and registered bits against the events of the previous cycle.

// File: rtl/flow_status_pkg.sv
package flow_status_pkg;
  localparam int STAT_W      = 8;
  localparam int BIT_LOCAL   = 0;
  localparam int BIT_REMOTE  = 1;
  localparam int BIT_RTS     = 2;
  localparam int BIT_DTR     = 3;
  localparam int BIT_SPECIAL = 4;
  localparam int BIT_FSEL    = 5;
  localparam int BIT_DEPTH   = 6;
  localparam int BIT_IDLE    = 7;

  typedef struct packed {
    logic setLocal;
    logic clrLocal;
    logic setRemote;
    logic clrRemote;
    logic setSpecial;
    logic clrSpecial;
    logic fireXon;
  } flowStrobes_t;
endpackage

// File: rtl/flow_status_ctrl.sv
module flow_status_ctrl
  import flow_status_pkg::*;
(
  input  logic              chanSwReset,
  input  logic              rxXoffDet,
  input  logic              rxSpecialStored,
  input  logic              txXoffSent,
  input  logic              txXonSent,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [STAT_W-1:0] regWrData,
  input  logic              remoteStop,
  output flowStrobes_t      strobes
);
  logic wrZeroLocal;
  logic wrZeroRemote;

  always_comb begin
    wrZeroLocal  = regWrEn && !regWrData[BIT_LOCAL];
    wrZeroRemote = regWrEn && !regWrData[BIT_REMOTE] && remoteStop;

    // events win over host writes, channel reset wins over everything
    strobes.setLocal   = rxXoffDet && !chanSwReset;
    strobes.clrLocal   = chanSwReset || (wrZeroLocal && !rxXoffDet);
    strobes.setRemote  = txXoffSent && !chanSwReset;
    strobes.clrRemote  = chanSwReset || ((txXonSent || wrZeroRemote) && !txXoffSent);
    strobes.fireXon    = wrZeroRemote && !txXoffSent && !chanSwReset;
    strobes.setSpecial = rxSpecialStored;
    strobes.clrSpecial = regRdEn && !rxSpecialStored;
  end
endmodule

// File: rtl/flow_status_dp.sv
module flow_status_dp
  import flow_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  flowStrobes_t      strobes,
  input  logic              txFifoEmpty,
  input  logic              txShiftEmpty,
  input  logic              rtsPin,
  input  logic              dtrPin,
  input  logic              loopbackEn,
  input  logic              rtsFlowHalt,
  input  logic              dtrFlowHalt,
  input  logic              fifoSelPin,
  input  logic              fifoDeep,
  output logic              remoteStop,
  output logic [STAT_W-1:0] statWord,
  output logic              txHalted,
  output logic              xonRequest
);
  logic localStop;
  logic specialSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      localStop   <= 1'b0;
      remoteStop  <= 1'b0;
      specialSeen <= 1'b0;
      xonRequest  <= 1'b0;
    end else begin
      if (strobes.setLocal)        localStop <= 1'b1;
      else if (strobes.clrLocal)   localStop <= 1'b0;
      if (strobes.setRemote)       remoteStop <= 1'b1;
      else if (strobes.clrRemote)  remoteStop <= 1'b0;
      if (strobes.setSpecial)      specialSeen <= 1'b1;
      else if (strobes.clrSpecial) specialSeen <= 1'b0;
      xonRequest <= strobes.fireXon;
    end
  end

  always_comb begin
    statWord              = '0;
    statWord[BIT_LOCAL]   = localStop;
    statWord[BIT_REMOTE]  = remoteStop;
    statWord[BIT_RTS]     = loopbackEn ? rtsFlowHalt : !rtsPin;
    statWord[BIT_DTR]     = loopbackEn ? dtrFlowHalt : !dtrPin;
    statWord[BIT_SPECIAL] = specialSeen;
    statWord[BIT_FSEL]    = fifoSelPin;
    statWord[BIT_DEPTH]   = fifoDeep;
    statWord[BIT_IDLE]    = txFifoEmpty && txShiftEmpty;
  end

  assign txHalted = localStop;
endmodule

// File: rtl/flow_status_reg.sv
module flow_status_reg
  import flow_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              chanSwReset,
  input  logic              rxXoffDet,
  input  logic              rxSpecialStored,
  input  logic              txXoffSent,
  input  logic              txXonSent,
  input  logic              txFifoEmpty,
  input  logic              txShiftEmpty,
  input  logic              rtsPin,
  input  logic              dtrPin,
  input  logic              loopbackEn,
  input  logic              rtsFlowHalt,
  input  logic              dtrFlowHalt,
  input  logic              fifoSelPin,
  input  logic              fifoDeep,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [STAT_W-1:0] regWrData,
  output logic [STAT_W-1:0] regRdData,
  output logic              txHalted,
  output logic              xonRequest
);
  flowStrobes_t strobes;
  logic         remoteStop;

  flow_status_ctrl u_ctrl (
    .chanSwReset    (chanSwReset),
    .rxXoffDet      (rxXoffDet),
    .rxSpecialStored(rxSpecialStored),
    .txXoffSent     (txXoffSent),
    .txXonSent      (txXonSent),
    .regWrEn        (regWrEn),
    .regRdEn        (regRdEn),
    .regWrData      (regWrData),
    .remoteStop     (remoteStop),
    .strobes        (strobes)
  );

  flow_status_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .txFifoEmpty (txFifoEmpty),
    .txShiftEmpty(txShiftEmpty),
    .rtsPin      (rtsPin),
    .dtrPin      (dtrPin),
    .loopbackEn  (loopbackEn),
    .rtsFlowHalt (rtsFlowHalt),
    .dtrFlowHalt (dtrFlowHalt),
    .fifoSelPin  (fifoSelPin),
    .fifoDeep    (fifoDeep),
    .remoteStop  (remoteStop),
    .statWord    (regRdData),
    .txHalted    (txHalted),
    .xonRequest  (xonRequest)
  );
endmodule

// File: rtl/flow_status_chk.sv
module flow_status_chk (
  input logic       clk,
  input logic       rstN,
  input logic       chanSwReset,
  input logic       rxXoffDet,
  input logic       rxSpecialStored,
  input logic       txXoffSent,
  input logic       txXonSent,
  input logic       txFifoEmpty,
  input logic       txShiftEmpty,
  input logic       fifoSelPin,
  input logic       regWrEn,
  input logic       regRdEn,
  input logic [7:0] regWrData,
  input logic [7:0] regRdData,
  input logic       txHalted,
  input logic       xonRequest
);
  p_xoff_sets_r1: assert property (@(posedge clk) disable iff (!rstN)
    (rxXoffDet && !chanSwReset) |=> (regRdData[0] && txHalted));

  p_one_keeps_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrData[0] && regRdData[0] && !chanSwReset) |=> regRdData[0]);

  p_xon_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    (txXonSent && !txXoffSent) |=> !regRdData[1]);

  p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    xonRequest |=> !xonRequest);

  p_pulse_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    xonRequest |-> ($past(regWrEn) && !$past(regWrData[1]) && !regRdData[1]));

  p_sw_reset_r5: assert property (@(posedge clk) disable iff (!rstN)
    chanSwReset |=> (!regRdData[0] && !regRdData[1] && !xonRequest));

  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && !rxSpecialStored) |=> !regRdData[4]);

  p_special_sets_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxSpecialStored |=> regRdData[4]);

  p_fifo_sel_r8: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[5] == fifoSelPin);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[7] |-> (txFifoEmpty && txShiftEmpty));
endmodule

bind flow_status_reg flow_status_chk u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .chanSwReset    (chanSwReset),
  .rxXoffDet      (rxXoffDet),
  .rxSpecialStored(rxSpecialStored),
  .txXoffSent     (txXoffSent),
  .txXonSent      (txXonSent),
  .txFifoEmpty    (txFifoEmpty),
  .txShiftEmpty   (txShiftEmpty),
  .fifoSelPin     (fifoSelPin),
  .regWrEn        (regWrEn),
  .regRdEn        (regRdEn),
  .regWrData      (regWrData),
  .regRdData      (regRdData),
  .txHalted       (txHalted),
  .xonRequest     (xonRequest)
);

// File: tb/test_flow_status_reg.sv
`timescale 1ns/1ps
module test_flow_status_reg;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chanSwReset = 0, rxXoffDet = 0, rxSpecialStored = 0, txXoffSent = 0, txXonSent = 0;
  logic txFifoEmpty = 0, txShiftEmpty = 0, rtsPin = 0, dtrPin = 0, loopbackEn = 0;
  logic rtsFlowHalt = 0, dtrFlowHalt = 0, fifoSelPin = 0, fifoDeep = 0;
  logic regWrEn = 0, regRdEn = 0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic txHalted, xonRequest;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 0;

  // model state
  bit mLocal = 0, mRemote = 0, mSpecial = 0, mXon = 0;

  always #2 clk = ~clk;

  flow_status_reg i_flow_status_reg (
    .clk(clk), .rstN(rstN), .chanSwReset(chanSwReset), .rxXoffDet(rxXoffDet),
    .rxSpecialStored(rxSpecialStored), .txXoffSent(txXoffSent), .txXonSent(txXonSent),
    .txFifoEmpty(txFifoEmpty), .txShiftEmpty(txShiftEmpty), .rtsPin(rtsPin), .dtrPin(dtrPin),
    .loopbackEn(loopbackEn), .rtsFlowHalt(rtsFlowHalt), .dtrFlowHalt(dtrFlowHalt),
    .fifoSelPin(fifoSelPin), .fifoDeep(fifoDeep), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .regRdData(regRdData), .txHalted(txHalted), .xonRequest(xonRequest)
  );

  function automatic logic [7:0] expWord();
    logic [7:0] w;
    w[0] = mLocal;
    w[1] = mRemote;
    w[2] = loopbackEn ? rtsFlowHalt : !rtsPin;
    w[3] = loopbackEn ? dtrFlowHalt : !dtrPin;
    w[4] = mSpecial;
    w[5] = fifoSelPin;
    w[6] = fifoDeep;
    w[7] = txFifoEmpty && txShiftEmpty;
    return w;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    logic [7:0] e;
    e = expWord();
    check("R1/R2 local halt bit",     {7'd0, regRdData[0]}, {7'd0, e[0]});
    check("R1 txHalted",              {7'd0, txHalted},     {7'd0, mLocal});
    check("R3/R4 remote halt bit",    {7'd0, regRdData[1]}, {7'd0, e[1]});
    check("R4 xonRequest",            {7'd0, xonRequest},   {7'd0, mXon});
    check("R6 pin status bits",       {6'd0, regRdData[3:2]}, {6'd0, e[3:2]});
    check("R7 special bit",           {7'd0, regRdData[4]}, {7'd0, e[4]});
    check("R8 strap bits",            {6'd0, regRdData[6:5]}, {6'd0, e[6:5]});
    check("R9 idle bit",              {7'd0, regRdData[7]}, {7'd0, e[7]});
  endtask

  // step the model on a rising edge using the inputs of the ending cycle
  task automatic stepModel();
    bit wrClrRemote;
    wrClrRemote = regWrEn && !regWrData[1] && mRemote;
    if (chanSwReset) begin
      mLocal = 0; mRemote = 0; mXon = 0;
    end else begin
      if (regWrEn && !regWrData[0]) mLocal = 0;
      if (rxXoffDet) mLocal = 1;
      mXon = wrClrRemote && !txXoffSent;
      if (txXonSent || wrClrRemote) mRemote = 0;
      if (txXoffSent) mRemote = 1;
    end
    if (regRdEn) mSpecial = 0;
    if (rxSpecialStored) mSpecial = 1;
  endtask

  task automatic runCycle();
    #1;
    checkAll();
    @(posedge clk);
    stepModel();
    @(negedge clk);
  endtask

  task automatic quiet();
    chanSwReset = 0; rxXoffDet = 0; rxSpecialStored = 0; txXoffSent = 0; txXonSent = 0;
    regWrEn = 0; regRdEn = 0; regWrData = 8'hFF;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    quiet();
    txFifoEmpty = 1; txShiftEmpty = 1; fifoDeep = 1;
    @(negedge clk); @(negedge clk);
    #1;
    // R5: hardware reset state
    check("R5 reset word bits 4,1,0", {5'd0, regRdData[4], regRdData[1:0]}, 8'd0);
    check("R5 reset xonRequest", {7'd0, xonRequest}, 8'd0);
    @(negedge clk);
    rstN = 1;
    runCycle();

    // R1 then R2: clear by write while xoff repeats, then plain clear
    rxXoffDet = 1; runCycle(); quiet();
    regWrEn = 1; regWrData = 8'hFE; rxXoffDet = 1; runCycle(); quiet();
    regWrEn = 1; regWrData = 8'hFF; runCycle(); quiet();
    regWrEn = 1; regWrData = 8'hFE; runCycle(); quiet();
    runCycle();

    // R3/R4: xoff sent, then zero write coinciding with a new xoff
    txXoffSent = 1; runCycle(); quiet();
    regWrEn = 1; regWrData = 8'hFD; txXoffSent = 1; runCycle(); quiet();
    regWrEn = 1; regWrData = 8'hFD; runCycle(); quiet();
    runCycle();
    txXoffSent = 1; txXonSent = 1; runCycle(); quiet();
    txXonSent = 1; runCycle(); quiet();

    // R7: special and read in the same cycle, then read alone
    rxSpecialStored = 1; regRdEn = 1; runCycle(); quiet();
    regRdEn = 1; runCycle(); quiet();

    // R5: channel reset beats events
    rxXoffDet = 1; txXoffSent = 1; runCycle(); quiet();
    chanSwReset = 1; rxXoffDet = 1; txXoffSent = 1; runCycle(); quiet();

    // R10: upper write bits have no effect on the read word
    rtsPin = 1; dtrPin = 0; fifoSelPin = 1; fifoDeep = 0; txShiftEmpty = 0;
    regWrEn = 1; regWrData = 8'hFF; runCycle(); quiet();
    #1;
    check("R10 write of ones leaves word", regRdData, expWord());
    regWrEn = 1; regWrData = 8'h03; #1;
    @(posedge clk); stepModel(); @(negedge clk); quiet();
    #1;
    check("R10 upper zero write leaves word", regRdData, expWord());
    @(negedge clk);

    // R6: loopback source switch
    loopbackEn = 1; rtsFlowHalt = 1; dtrFlowHalt = 0; rtsPin = 1; dtrPin = 1; runCycle();
    loopbackEn = 0; runCycle();

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      chanSwReset     = ($urandom % 40) == 0;
      rxXoffDet       = ($urandom % 8) == 0;
      rxSpecialStored = ($urandom % 8) == 0;
      txXoffSent      = ($urandom % 8) == 0;
      txXonSent       = ($urandom % 8) == 0;
      regWrEn         = ($urandom % 4) == 0;
      regRdEn         = ($urandom % 4) == 0;
      regWrData       = 8'($urandom);
      txFifoEmpty     = 1'($urandom);
      txShiftEmpty    = 1'($urandom);
      rtsPin          = 1'($urandom);
      dtrPin          = 1'($urandom);
      loopbackEn      = 1'($urandom);
      rtsFlowHalt     = 1'($urandom);
      dtrFlowHalt     = 1'($urandom);
      fifoSelPin      = 1'($urandom);
      fifoDeep        = 1'($urandom);
      runCycle();
    end
    quiet();
    runCycle();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule